// File: doc/BRIEF.md
# Seeded Additive Test Pattern Generator

This block produces a test sequence from a single accumulator. A preset pulse loads an externally supplied seed as pattern number 0, and from then on every enabled clock adds a fixed increment to the current pattern, modulo 2^W. Any carry out of the top bit is dropped, so the sequence wraps around silently. Pattern number i is therefore seed + i * step (mod 2^W).

The run length is bounded by a target index that is captured at preset. The run ends when the pattern index reaches that target. The generator then raises its done flag and holds both pattern and index until the next preset. A run never needs 2^W patterns or more, so the index and the target share the pattern width.

The control is a three-state machine:
- ST_IDLE is entered by reset. The datapath is cleared and nothing advances.
- ST_RUN steps the accumulator on every enabled clock.
- ST_DONE holds everything.

The transitions are:
- T_LOAD: preset, from any state, goes to ST_RUN.
- T_LOAD0: preset with a zero target goes straight to ST_DONE.
- T_STEP: an enabled step in ST_RUN that does not reach the target stays in ST_RUN.
- T_FINISH: an enabled step whose new index equals the target goes to ST_DONE.
- T_HOLD: in every other case the state is kept.

Top module: `addgen_tpg`

## Requirements
- R1: A preset in any state loads the seed onto the pattern output and sets the index to 0 on the next clock edge. Preset takes priority over enable and over the done state.
- R2: In the running state, each clock with enable high and preset low replaces the pattern with pattern + step and raises the index by one.
- R3: The addition is modulo 2^W. The carry out of bit W-1 is discarded, so for example 60 + 7 with W = 6 gives 3.
- R4: As long as step is held constant, after i steps from a preset the pattern equals seed + i * step (mod 2^W).
- R5: When an enabled step makes the index equal to the target captured at preset, done goes high on that same edge. Afterwards pattern, index and done hold until the next preset or reset.
- R6: With enable low and preset low, the pattern and the index keep their values.
- R7: A synchronous active-high reset clears the pattern, the index and done to 0. After reset and before the first preset, enable has no effect.
- R8: A preset with a target of 0 loads the seed with index 0 and raises done on the same edge.
- R9: The target is sampled only at preset. A change on the target input during a run does not move the point where done rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| preset | input | 1 | Load the seed as pattern 0 and capture the target |
| enable | input | 1 | Allow one step per clock |
| seed | input | W | First pattern of the sequence |
| step | input | W | Increment added on each step |
| target | input | W | Index at which the run ends (sampled at preset) |
| pattern | output | W | Current test pattern |
| index | output | W | Number of steps since preset |
| done | output | 1 | Run has reached the target index |

## Verification
The bench builds the generator with W = 6 instead of the default 8. At that width a wrap-around of the adder is only a few steps away. A run of the longest allowed length, 63 steps, also fits in a short bench. With W = 6 the bench replays an increment of 63, which walks downward through 0, 63, 62, 61 and so on. It also exercises a target of 0, a restart by preset in the middle of a run, and a target change in the middle of a run. At every clock a scoreboard compares pattern, index and done against a model written from the requirements.

// File: rtl/addgen_tpg_pkg.sv
package addgen_tpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } gen_state_e;

endpackage

// File: rtl/addgen_mod_adder.sv
// Ripple adder that never forms the carry out of the top bit, so the
// result is the sum modulo 2^W.
module addgen_mod_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);

    logic [W-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign sum[g] = a[g] ^ b[g] ^ carry[g];
        if (g < W - 1) begin : g_carry
            assign carry[g+1] = (a[g] & b[g]) | (a[g] & carry[g]) | (b[g] & carry[g]);
        end
    end

endmodule

// File: rtl/addgen_seq_ctrl.sv
module addgen_seq_ctrl
    import addgen_tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       preset,
    input  logic       enable,
    input  logic       tgt_zero,
    input  logic       at_last,
    output gen_state_e st,
    output logic       ld,
    output logic       adv,
    output logic       done
);

    gen_state_e nxt;

    // Next-state selection
    always_comb begin
        nxt = st;
        if (preset) begin
            nxt = tgt_zero ? ST_DONE : ST_RUN;      // T_LOAD0 / T_LOAD
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;             // T_HOLD
                ST_RUN:  nxt = (enable && at_last) ? ST_DONE : ST_RUN; // T_FINISH / T_STEP
                ST_DONE: nxt = ST_DONE;             // T_HOLD
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    // Outputs decoded from the state
    always_comb begin
        ld   = preset;
        adv  = 1'b0;
        done = 1'b0;
        unique case (st)
            ST_IDLE: adv = 1'b0;
            ST_RUN:  adv = enable && !preset;
            ST_DONE: done = 1'b1;
            default: adv = 1'b0;
        endcase
    end

endmodule

// File: rtl/addgen_datapath.sv
module addgen_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         adv,
    input  logic [W-1:0] seed,
    input  logic [W-1:0] step,
    input  logic [W-1:0] target,
    output logic [W-1:0] pattern,
    output logic [W-1:0] index,
    output logic [W-1:0] tgt_q,
    output logic         tgt_zero,
    output logic         at_last
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] pat_nxt;
    logic [W-1:0] idx_nxt;

    addgen_mod_adder #(.W(W)) u_pat_add (
        .a   (pattern),
        .b   (step),
        .sum (pat_nxt)
    );

    addgen_mod_adder #(.W(W)) u_idx_add (
        .a   (index),
        .b   (ONE),
        .sum (idx_nxt)
    );

    assign tgt_zero = (target == '0);
    assign at_last  = (idx_nxt == tgt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pattern <= '0;
            index   <= '0;
            tgt_q   <= '0;
        end else if (ld) begin
            pattern <= seed;
            index   <= '0;
            tgt_q   <= target;
        end else if (adv) begin
            pattern <= pat_nxt;
            index   <= idx_nxt;
        end
    end

endmodule

// File: rtl/addgen_tpg.sv
module addgen_tpg
    import addgen_tpg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preset,
    input  logic         enable,
    input  logic [W-1:0] seed,
    input  logic [W-1:0] step,
    input  logic [W-1:0] target,
    output logic [W-1:0] pattern,
    output logic [W-1:0] index,
    output logic         done
);

    gen_state_e   st;
    logic         ld;
    logic         adv;
    logic         tgt_zero;
    logic         at_last;
    logic [W-1:0] tgt_q;

    addgen_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .preset   (preset),
        .enable   (enable),
        .tgt_zero (tgt_zero),
        .at_last  (at_last),
        .st       (st),
        .ld       (ld),
        .adv      (adv),
        .done     (done)
    );

    addgen_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld),
        .adv      (adv),
        .seed     (seed),
        .step     (step),
        .target   (target),
        .pattern  (pattern),
        .index    (index),
        .tgt_q    (tgt_q),
        .tgt_zero (tgt_zero),
        .at_last  (at_last)
    );

endmodule

// File: rtl/addgen_tpg_chk.sv
module addgen_tpg_chk
    import addgen_tpg_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         preset,
    input logic         enable,
    input logic [W-1:0] seed,
    input logic [W-1:0] step,
    input logic [W-1:0] pattern,
    input logic [W-1:0] index,
    input logic [W-1:0] tgt_q,
    input logic         done,
    input gen_state_e   st
);

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (pattern == '0 && index == '0 && !done));

    p_preset_load_r1: assert property (@(posedge clk) disable iff (rst)
        preset |=> (pattern == $past(seed) && index == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (!preset && enable && st == ST_RUN) |=>
            (pattern == W'($past(pattern) + $past(step)) && index == W'($past(index) + 1'b1)));

    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (!preset && !enable) |=> ($stable(pattern) && $stable(index)));

    p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !preset) |=> (done && $stable(pattern) && $stable(index)));

    p_done_index_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (index == tgt_q));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !preset) |=> (pattern == '0 && index == '0 && !done));

endmodule

bind addgen_tpg addgen_tpg_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .preset  (preset),
    .enable  (enable),
    .seed    (seed),
    .step    (step),
    .pattern (pattern),
    .index   (index),
    .tgt_q   (tgt_q),
    .done    (done),
    .st      (st)
);

// File: tb/sim_addgen_tpg.sv
module sim_addgen_tpg;

    localparam int BW       = 6;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 20000;

    typedef struct packed {
        logic [BW-1:0] p;
        logic [BW-1:0] i;
        logic          d;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          preset = 1'b0;
    logic          enable = 1'b0;
    logic [BW-1:0] seed = '0;
    logic [BW-1:0] step = '0;
    logic [BW-1:0] target = '0;
    logic [BW-1:0] pattern;
    logic [BW-1:0] index;
    logic          done;

    int errors = 0;
    int checks = 0;
    bit stim_done = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    // Reference model state
    logic [BW-1:0] m_pat = '0;
    logic [BW-1:0] m_idx = '0;
    logic [BW-1:0] m_tgt = '0;
    logic          m_done = 1'b0;
    logic          m_live = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    addgen_tpg #(.W(BW)) u0 (
        .clk     (clk),
        .rst     (rst),
        .preset  (preset),
        .enable  (enable),
        .seed    (seed),
        .step    (step),
        .target  (target),
        .pattern (pattern),
        .index   (index),
        .done    (done)
    );

    // Driver: one clock of stimulus, model update, expected item pushed
    task automatic cyc(input logic r, input logic pr, input logic en,
                       input logic [BW-1:0] sd, input logic [BW-1:0] st,
                       input logic [BW-1:0] tg, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; preset = pr; enable = en; seed = sd; step = st; target = tg;
        if (r) begin
            m_pat = '0; m_idx = '0; m_tgt = '0; m_done = 1'b0; m_live = 1'b0;
        end else if (pr) begin
            m_pat = sd; m_idx = '0; m_tgt = tg; m_live = 1'b1;
            m_done = (tg == '0);
        end else if (en && m_live && !m_done) begin
            m_pat = BW'(m_pat + st);
            m_idx = BW'(m_idx + 1);
            m_done = (m_idx == m_tgt);
        end
        e.p = m_pat; e.i = m_idx; e.d = m_done;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic check(input string tag, input logic [BW-1:0] act,
                         input logic [BW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: pops the expected item after each edge and compares
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pattern !== e.p || index !== e.i || done !== e.d) begin
                    errors++;
                    $display("FAIL %s: actual p=%0d i=%0d d=%0b expected p=%0d i=%0d d=%0b",
                             t, pattern, index, done, e.p, e.i, e.d);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!stim_done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R7: reset clears, then enable without preset has no effect
        cyc(1, 0, 0, 0, 0, 0, "R7 reset");
        cyc(1, 1, 1, 6'd9, 6'd4, 6'd3, "R7 reset over preset");
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, 6'd9, 6'd4, 6'd3, "R7 idle enable");

        // R1 R2 R5: seed 5, step 3, target 10, run past the end
        cyc(0, 1, 1, 6'd5, 6'd3, 6'd10, "R1 preset load");
        for (int k = 0; k < 13; k++) cyc(0, 0, 1, 6'd5, 6'd3, 6'd10, "R2 R5 step/hold");

        // R3: wrap 60 + 7 -> 3
        cyc(0, 1, 0, 6'd60, 6'd7, 6'd5, "R1 preset with enable low");
        for (int k = 0; k < 6; k++) cyc(0, 0, 1, 6'd60, 6'd7, 6'd5, "R3 wrap");

        // R4: step 63 walks downward 0,63,62,61,60,59
        cyc(0, 1, 0, 6'd0, 6'd63, 6'd5, "R4 preset");
        for (int k = 0; k < 5; k++) cyc(0, 0, 1, 6'd0, 6'd63, 6'd5, "R4 sequence");
        @(posedge clk); #2;
        check("R4 closed form pattern", pattern, BW'(0 + 5 * 63));
        check("R5 done index", index, 6'd5);

        // R6: enable toggling freezes
        cyc(0, 1, 0, 6'd11, 6'd13, 6'd8, "R6 preset");
        for (int k = 0; k < 12; k++) cyc(0, 0, (k % 3) == 0, 6'd11, 6'd13, 6'd8, "R6 freeze");

        // R8: target zero
        cyc(0, 1, 1, 6'd42, 6'd1, 6'd0, "R8 zero target");
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, 6'd42, 6'd1, 6'd0, "R8 hold");

        // R1: restart mid-run, R9: target change mid-run ignored
        cyc(0, 1, 1, 6'd2, 6'd2, 6'd20, "R1 preset");
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 6'd2, 6'd2, 6'd20, "R2 run");
        cyc(0, 1, 1, 6'd7, 6'd5, 6'd4, "R1 restart");
        for (int k = 0; k < 7; k++) cyc(0, 0, 1, 6'd7, 6'd5, 6'd1, "R9 target change");

        // R3 R5: longest run, 63 steps of 1 from seed 1 ends at 0
        cyc(0, 1, 1, 6'd1, 6'd1, 6'd63, "R5 long preset");
        for (int k = 0; k < 65; k++) cyc(0, 0, 1, 6'd1, 6'd1, 6'd63, "R3 R5 long run");
        @(posedge clk); #2;
        check("R3 long run final pattern", pattern, 6'd0);
        check("R5 long run final index", index, 6'd63);

        // R7: reset mid-hold
        cyc(1, 0, 1, 6'd1, 6'd1, 6'd63, "R7 reset again");
        cyc(0, 0, 1, 6'd1, 6'd1, 6'd63, "R7 after reset");

        @(posedge clk); #3;
        @(posedge clk); #3;
        stim_done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule